// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable integer and marks every completed division with a one-cycle output pulse. It sits in the feedback path of a frequency synthesizer. The division is built from three parts. A prescaler counts either P or P+1 input cycles, with P set to 5 or 10. A swallow counter decides how many prescaler cycles at the start of each output period use the longer modulus. A main counter counts prescaler cycles and ends the output period after M+1 of them. The resulting ratio is P·(M+1)+A.

With the prescaler disabled, each input cycle counts as one prescaler cycle, and the ratio becomes M+1. In that mode the swallow value and the modulus choice have no effect. New settings may arrive at any time. The block only takes them in at the edge that closes an output period, so a period that has already started always finishes with the settings it began with. The prescaler-enable input is active low.

Top module: `psd_divider`

## Requirements
- R1: With `pre_en_n`=0 and `sel_ten`=1, the number of input clock edges from one output pulse to the next is 10·(M+1)+A.
- R2: With `pre_en_n`=0 and `sel_ten`=0, that count is 5·(M+1)+A.
- R3: With `pre_en_n`=1, that count is M+1, whatever `a_in` and `sel_ten` hold.
- R4: The swallow boundaries give exact ratios. A=0 gives P·(M+1). A=M+1 (every prescaler cycle long) gives (M+1)·(P+1).
- R5: The smallest legal M of 1 gives a count of 2 in bypass mode, and 2·P+A in normal mode.
- R6: `m_in`, `a_in`, `sel_ten` and `pre_en_n` are sampled only at the clock edge that ends an output period, and also at every edge while `rst` is high. A change in mid-period leaves the length of the current period unchanged.
- R7: `div_pulse` is high for exactly one clock cycle per output period when M is at least 1.
- R8: `rst` is synchronous and active high. `div_pulse` is low in the cycle after any edge with `rst` high. After release, the first pulse is seen after the N-th edge with `rst` low, where N is the ratio of the settings present at the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset; loads settings |
| m_in | input | 9 | Main counter setting M, legal 1 to 511 |
| a_in | input | 4 | Swallow count A, 0 to 15 and at most M+1 |
| sel_ten | input | 1 | 1 selects the 10/11 prescaler, 0 the 5/6 prescaler |
| pre_en_n | input | 1 | Active-low prescaler enable; 1 bypasses prescaler and swallow |
| div_pulse | output | 1 | Registered one-cycle pulse per output period |

## Verification
When A equals M+1, the swallow counter reaches zero in the same prescaler cycle in which the main counter hits its terminal count and reloads. At that edge the swallow counter must take the fresh A rather than its decremented value, so the next period opens on the long modulus again. The bench provokes this case with A=M+1 under both prescaler sizes, and it also changes the settings a single cycle before a boundary. It judges each case by counting input edges between pulses against (M+1)·(P+1) for the period that ends and the ratio of the newly sampled settings for the period after it.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;

  typedef enum logic [1:0] {
    MODE_LOW    = 2'd0,
    MODE_HIGH   = 2'd1,
    MODE_BYPASS = 2'd2
  } psd_mode_e;

  function automatic psd_mode_e decode_mode(input logic en_n, input logic ten);
    if (en_n)     return MODE_BYPASS;
    else if (ten) return MODE_HIGH;
    else          return MODE_LOW;
  endfunction

endpackage

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int P_LOW  = 5,
  parameter int P_HIGH = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  psd_mode_e mode,
  input  logic      long_cyc,
  output logic      wrap
);
  localparam int PRE_W = $clog2(P_HIGH + 1);
  localparam logic [PRE_W-1:0] LAST_LO = PRE_W'(P_LOW - 1);
  localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(P_HIGH - 1);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] last;

  always_comb begin
    unique case (mode)
      MODE_HIGH: last = LAST_HI + {{(PRE_W-1){1'b0}}, long_cyc};
      MODE_LOW:  last = LAST_LO + {{(PRE_W-1){1'b0}}, long_cyc};
      default:   last = '0;
    endcase
  end

  assign wrap = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || wrap) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psd_swallow.sv
`timescale 1ns/1ps
module psd_swallow #(
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] load_val,
  input  logic           step,
  output logic [A_W-1:0] cnt,
  output logic           long_cyc
);
  assign long_cyc = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || load)           cnt <= load_val;
    else if (step && long_cyc) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/psd_main.sv
`timescale 1ns/1ps
module psd_main #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic [M_W-1:0] limit,
  output logic           term
);
  logic [M_W-1:0] cnt;

  assign term = step && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= term ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/psd_divider.sv
`timescale 1ns/1ps
module psd_divider
  import psd_pkg::*;
#(
  parameter int M_W    = 9,
  parameter int A_W    = 4,
  parameter int P_LOW  = 5,
  parameter int P_HIGH = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           sel_ten,
  input  logic           pre_en_n,
  output logic           div_pulse
);
  psd_mode_e      cfg_mode;
  logic [M_W-1:0] cfg_m;
  logic [A_W-1:0] swal_cnt;
  logic           long_cyc;
  logic           pre_wrap;
  logic           period_end;

  always_ff @(posedge clk) begin
    if (rst || period_end) begin
      cfg_m    <= m_in;
      cfg_mode <= decode_mode(pre_en_n, sel_ten);
    end
  end

  psd_prescaler #(.P_LOW(P_LOW), .P_HIGH(P_HIGH)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .mode     (cfg_mode),
    .long_cyc (long_cyc),
    .wrap     (pre_wrap)
  );

  psd_swallow #(.A_W(A_W)) u_swal (
    .clk      (clk),
    .rst      (rst),
    .load     (period_end),
    .load_val (a_in),
    .step     (pre_wrap),
    .cnt      (swal_cnt),
    .long_cyc (long_cyc)
  );

  psd_main #(.M_W(M_W)) u_main (
    .clk   (clk),
    .rst   (rst),
    .step  (pre_wrap),
    .limit (cfg_m),
    .term  (period_end)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= period_end;
  end
endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/1ps
module psd_checker
  import psd_pkg::*;
#(
  parameter int M_W = 9,
  parameter int A_W = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           div_pulse,
  input logic           period_end,
  input logic           pre_wrap,
  input psd_mode_e      cfg_mode,
  input logic [M_W-1:0] cfg_m,
  input logic [A_W-1:0] swal_cnt
);
  p_reset_quiet_r8: assert property (@(posedge clk) rst |=> !div_pulse);

  p_end_pulses_r8: assert property (@(posedge clk) disable iff (rst)
    period_end |=> div_pulse);

  p_single_r7: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && cfg_m != '0) |=> !div_pulse);

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> ($stable(cfg_m) && $stable(cfg_mode)));

  p_bypass_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == MODE_BYPASS) |-> pre_wrap);

  p_swallow_down_r4: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> (swal_cnt <= $past(swal_cnt)));

  p_end_on_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    period_end |-> pre_wrap);
endmodule

bind psd_divider psd_checker #(.M_W(M_W), .A_W(A_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .div_pulse  (div_pulse),
  .period_end (period_end),
  .pre_wrap   (pre_wrap),
  .cfg_mode   (cfg_mode),
  .cfg_m      (cfg_m),
  .swal_cnt   (swal_cnt)
);

// File: tb/psd_divider_test.sv
`timescale 1ns/1ps
module psd_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] m_in = 9'd3;
  logic [3:0] a_in = 4'd2;
  logic       sel_ten = 1'b1;
  logic       pre_en_n = 1'b0;
  logic       div_pulse;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int cnt = 0;
  bit changed = 0;
  bit first_after_rst = 1;
  bit prev_pulse = 0;

  logic [8:0] mq, cur_m;
  logic [3:0] aq, cur_a;
  logic       sq, cur_s, eq, cur_e, rst_q;

  always #2.5 clk = ~clk;

  psd_divider uut (
    .clk(clk), .rst(rst), .m_in(m_in), .a_in(a_in),
    .sel_ten(sel_ten), .pre_en_n(pre_en_n), .div_pulse(div_pulse)
  );

  function automatic int exp_ratio(int m, int a, bit s, bit e);
    if (e) return m + 1;
    return (s ? 10 : 5) * (m + 1) + a;
  endfunction

  function automatic string tag_for(int m, int a, bit s, bit e);
    if (m == 1)              return "R5";
    if (e)                   return "R3";
    if (a == 0 || a == m + 1) return "R4";
    return s ? "R1" : "R2";
  endfunction

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // settings as seen by the design at each edge
  always @(posedge clk) begin
    mq <= m_in; aq <= a_in; sq <= sel_ten; eq <= pre_en_n; rst_q <= rst;
  end

  always @(negedge clk) begin
    if (rst_q) begin
      checks++;
      if (div_pulse !== 1'b0) begin
        fails++;
        $display("FAIL R8 pulse during reset: got %b expected 0", div_pulse);
      end
      cur_m = mq; cur_a = aq; cur_s = sq; cur_e = eq;
      cnt = 0; first_after_rst = 1; changed = 0; prev_pulse = 0;
    end else begin
      cnt++;
      if (prev_pulse) begin
        checks++;
        if (div_pulse !== 1'b0) begin
          fails++;
          $display("FAIL R7 pulse wider than one cycle: got %b expected 0", div_pulse);
        end
      end
      if (div_pulse === 1'b1) begin
        string t;
        int    e;
        e = exp_ratio(cur_m, cur_a, cur_s, cur_e);
        t = first_after_rst ? "R8" : (changed ? "R6" : tag_for(cur_m, cur_a, cur_s, cur_e));
        checks++;
        if (cnt != e) begin
          fails++;
          $display("FAIL %s period M=%0d A=%0d ten=%0d byp=%0d: got %0d expected %0d",
                   t, cur_m, cur_a, cur_s, cur_e, cnt, e);
        end
        cur_m = mq; cur_a = aq; cur_s = sq; cur_e = eq;
        cnt = 0; first_after_rst = 0; changed = 0; pulses++;
      end
      prev_pulse = (div_pulse === 1'b1);
      if (cnt > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog: no pulse after %0d cycles, expected %0d",
                 cnt, exp_ratio(cur_m, cur_a, cur_s, cur_e));
        summary_and_end();
      end
    end
  end

  task automatic set_cfg(int m, int a, bit s, bit e);
    @(posedge clk); #1;
    m_in = 9'(m); a_in = 4'(a); sel_ten = s; pre_en_n = e;
    changed = 1;
  endtask

  task automatic wait_pulses(int k);
    int target;
    target = pulses + k;
    while (pulses < target) @(negedge clk);
  endtask

  task automatic run_cfg(int m, int a, bit s, bit e);
    set_cfg(m, a, s, e);
    wait_pulses(2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    wait_pulses(2);                // R8 first pulse: 10*4+2 = 42

    run_cfg(511, 15, 1, 0);        // R1 largest M
    run_cfg(1, 0, 1, 0);           // R5 normal minimum: 20
    run_cfg(1, 2, 1, 0);           // R5 / A=M+1: 22
    run_cfg(9, 10, 1, 0);          // R4 A=M+1 on 10/11: 110
    run_cfg(4, 5, 0, 0);           // R4 A=M+1 on 5/6: 30
    run_cfg(7, 0, 0, 0);           // R4 A=0: 40
    run_cfg(14, 15, 0, 0);         // R4 A=15=M+1: 90
    run_cfg(6, 3, 0, 0);           // R2: 38
    run_cfg(6, 3, 1, 0);           // R1: 73
    run_cfg(511, 0, 0, 0);         // R4: 2560
    run_cfg(1, 7, 1, 1);           // R5 bypass: 2
    run_cfg(511, 3, 0, 1);         // R3 bypass ignores A and select: 512
    run_cfg(20, 9, 1, 1);          // R3: 21

    // R6: change settings one cycle before a boundary
    set_cfg(5, 6, 1, 0);           // 66 cycles
    wait_pulses(1);
    repeat (64) @(negedge clk);
    set_cfg(2, 1, 0, 0);
    wait_pulses(2);

    for (int i = 0; i < 40; i++) begin
      int m, a, d;
      m = $urandom_range(1, 63);
      a = $urandom_range(0, (m + 1 > 15) ? 15 : m + 1);
      d = $urandom_range(0, 300);
      repeat (d) @(negedge clk);
      set_cfg(m, a, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
      wait_pulses(1 + $urandom_range(0, 1));
    end

    // R8: reset in mid-period, new settings captured during reset: 5*3+3 = 18
    repeat (7) @(negedge clk);
    @(posedge clk); #1;
    rst = 1'b1; m_in = 9'd2; a_in = 4'd3; sel_ten = 1'b0; pre_en_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    wait_pulses(2);

    summary_and_end();
  end
endmodule